// File: doc/BRIEF.md
# Static Memory Write Phase Sequencer

This block drives a single write to an external static memory bank (SRAM, PSRAM or NOR). When it is idle it takes one request: an address, a data word, and two flags that pick synchronous or asynchronous timing and a shared or separate address/data bus. It then steps through three phases: address setup, address hold and data. Each phase lasts a number of controller clock cycles. When the data phase ends, the block raises a one-cycle completion pulse.

The phase lengths come from a packed 32-bit write-timing word. The flags decide how its fields are used. Synchronous writes ignore the fields and take one cycle per phase. A shared bus forces at least one setup cycle. The hold field applies only to asynchronous shared-bus writes, or to any asynchronous write when the extended access mode 3 is selected. That mode selection counts only while the extended-mode input is high. The fields are sampled when the request is accepted.

Top module: `smem_write_seq`

## Requirements
- R1: The timing word is decoded as setup = bits 3:0, hold = bits 7:4, data = bits 15:8 and access mode = bits 29:28. Bits 19:16 (turnaround) and every other bit have no effect on the write.
- R2: An asynchronous write on a separate bus has exactly `setup` address setup cycles. A value of 0 removes the setup phase.
- R3: A synchronous write has exactly 1 setup cycle, 1 hold cycle and 1 data cycle, whatever the field values are.
- R4: An asynchronous write on a shared bus has max(1, setup) setup cycles.
- R5: An asynchronous write has `hold` hold cycles when the bus is shared or the effective access mode is 3. Otherwise it has no hold cycles.
- R6: The effective access mode is the mode field when `ext_mode_en` is 1, and 0 when it is 0.
- R7: An asynchronous write has max(1, data) data cycles.
- R8: `mem_ce_n` is low (active) for the whole write. `mem_adv_n` is low only during setup. `mem_we_n` is low only during the data phase.
- R9: On a shared bus, `bus_out` carries the address (zero-extended or truncated to the bus width) during setup and hold, and the data during the data phase, with `bus_oe` high for the whole write. On a separate bus, `bus_oe` is high only during the data phase and `mem_addr` holds the address for the whole write.
- R10: `done` is high for exactly one cycle, in the cycle right after the last data cycle, with `mem_ce_n` already high. `req_ready` is high only when the block is idle. A request made during a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wtim | input | 32 | Write-timing word |
| ext_mode_en | input | 1 | Enables the access mode field |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | High while idle; a request is accepted only then |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_sync | input | 1 | 1 = synchronous timing |
| req_mux | input | 1 | 1 = shared address/data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low, during setup |
| mem_addr | output | AW | Address for a separate-bus memory |
| bus_out | output | DW | Data (or shared address/data) bus value |
| bus_oe | output | 1 | Bus output enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
Most faults in the phase counter or in the decoded lengths show up at the ports as a strobe window that is one or more cycles too long or too short, within the same write. The bench measures every window by counting cycles at the strobes, over a sweep of all setup values and a spread of hold and data values, in every mode. A wrong phase state shows up as overlapping strobes or a wrong value on the shared bus, either in the cycle where it happens or when the write finishes. A missing or doubled completion pulse shows up within one cycle of the data phase ending.

// File: rtl/smem_write_seq.sv
module smem_write_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   wtim,
  input  logic          ext_mode_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_sync,
  input  logic          req_mux,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          done
);

  localparam int CW = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_HOLD, ST_DATA} phase_t;

  phase_t        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_len, data_len;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          mux_q, sync_q;

  logic [3:0]    f_setup, f_hold;
  logic [7:0]    f_data;
  logic [1:0]    f_mode, mode_eff;
  logic [CW-1:0] su_len, ho_len, da_len;
  logic          accept;
  logic          unused_bits;

  assign f_setup  = wtim[3:0];
  assign f_hold   = wtim[7:4];
  assign f_data   = wtim[15:8];
  assign f_mode   = wtim[29:28];
  assign unused_bits = ^{wtim[31:30], wtim[27:16]};
  assign mode_eff = ext_mode_en ? f_mode : 2'd0;

  assign su_len = req_sync ? CW'(1) :
                  (req_mux && f_setup == 4'd0) ? CW'(1) : CW'(f_setup);
  assign ho_len = req_sync ? CW'(1) :
                  (req_mux || mode_eff == 2'd3) ? CW'(f_hold) : CW'(0);
  assign da_len = req_sync ? CW'(1) :
                  (f_data == 8'd0) ? CW'(1) : CW'(f_data);

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      hold_len <= '0;
      data_len <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      mux_q    <= 1'b0;
      sync_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          addr_q   <= req_addr;
          data_q   <= req_data;
          mux_q    <= req_mux;
          sync_q   <= req_sync;
          hold_len <= ho_len;
          data_len <= da_len;
          if (su_len != '0) begin
            st  <= ST_SETUP;
            cnt <= su_len - CW'(1);
          end else if (ho_len != '0) begin
            st  <= ST_HOLD;
            cnt <= ho_len - CW'(1);
          end else begin
            st  <= ST_DATA;
            cnt <= da_len - CW'(1);
          end
        end
        ST_SETUP: if (cnt != '0) cnt <= cnt - CW'(1);
          else if (hold_len != '0) begin
            st  <= ST_HOLD;
            cnt <= hold_len - CW'(1);
          end else begin
            st  <= ST_DATA;
            cnt <= data_len - CW'(1);
          end
        ST_HOLD: if (cnt != '0) cnt <= cnt - CW'(1);
          else begin
            st  <= ST_DATA;
            cnt <= data_len - CW'(1);
          end
        default: if (cnt != '0) cnt <= cnt - CW'(1);
          else begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
      endcase
    end
  end

  assign mem_ce_n  = (st == ST_IDLE);
  assign mem_we_n  = (st != ST_DATA);
  assign mem_adv_n = (st != ST_SETUP);
  assign mem_addr  = addr_q;
  assign bus_oe    = mux_q ? (st != ST_IDLE) : (st == ST_DATA);
  assign bus_out   = !bus_oe ? '0 :
                     (mux_q && st != ST_DATA) ? DW'(addr_q) : data_q;

  p_we_inside_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_adv_we_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_adv_n && !mem_we_n));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!mem_we_n) && mem_ce_n);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);
  p_sync_setup_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP && sync_q) |=> st != ST_SETUP);
  p_sync_data_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && sync_q) |=> mem_we_n);
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  p_we_needs_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> bus_oe);

endmodule

// File: tb/tb_smem_write_seq.sv
`timescale 1ns/1ps
module tb_smem_write_seq;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] wtim = '0;
  logic ext_mode_en = 1'b0, req_valid = 1'b0, req_sync = 1'b0, req_mux = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, mem_ce_n, mem_we_n, mem_adv_n, bus_oe, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] bus_out;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  smem_write_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wtim(wtim), .ext_mode_en(ext_mode_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_sync(req_sync), .req_mux(req_mux),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .bus_out(bus_out), .bus_oe(bus_oe), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int m_su, m_ho, m_da, m_bad_bus, m_bad_addr, m_total;
  bit m_done_ok;

  task automatic xfer(input logic [31:0] w, input bit ext, input bit sy, input bit mx,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int guard;
    m_su = 0; m_ho = 0; m_da = 0; m_bad_bus = 0; m_bad_addr = 0; m_total = 0;
    m_done_ok = 1'b0;
    @(negedge clk);
    wtim = w; ext_mode_en = ext; req_sync = sy; req_mux = mx;
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wtim = ~w;
    guard = 0;
    while (!done && guard < 600) begin
      if (poke && guard == 1) begin
        req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_mux = ~mx;
      end else req_valid = 1'b0;
      if (!mem_ce_n) begin
        m_total++;
        if (mem_addr != a) m_bad_addr++;
        if (!mem_adv_n) m_su++;
        else if (!mem_we_n) begin
          m_da++;
          if (!bus_oe || bus_out != d) m_bad_bus++;
        end else m_ho++;
        if (mx && mem_we_n && (!bus_oe || bus_out != DW'(a))) m_bad_bus++;
        if (!mx && mem_we_n && bus_oe) m_bad_bus++;
      end
      guard++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    m_done_ok = done && mem_ce_n && req_ready;
    @(negedge clk);
    if (done) m_done_ok = 1'b0;
  endtask

  function automatic int imax1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic run_case(input int as, input int ah, input int ds, input int md,
                          input bit ext, input bit sy, input bit mx, input int turn);
    logic [31:0] w;
    int es, eh, ed, meff;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    w = {2'b10, md[1:0], 8'h5A, turn[3:0], ds[7:0], ah[3:0], as[3:0]};
    a = AW'(as * 4099 + ah * 257 + ds + 16'h1234);
    d = DW'(ds * 771 + as * 33 + 16'h0F0F);
    meff = ext ? md : 0;
    es = sy ? 1 : (mx ? imax1(as) : as);
    eh = sy ? 1 : ((mx || meff == 3) ? ah : 0);
    ed = sy ? 1 : imax1(ds);
    xfer(w, ext, sy, mx, a, d, 1'b0);
    if (sy) chk(m_su == es && m_ho == eh && m_da == ed, "R3 sync phases", m_su*10000+m_ho*100+m_da, es*10000+eh*100+ed);
    else begin
      chk(m_su == es, mx ? "R4 mux setup" : "R2 setup", m_su, es);
      chk(m_ho == eh, (meff == 3 && !mx) ? "R6 R5 mode hold" : "R5 hold", m_ho, eh);
      chk(m_da == ed, "R7 data", m_da, ed);
    end
    chk(m_bad_bus == 0 && m_bad_addr == 0, "R9 bus content", m_bad_bus + m_bad_addr, 0);
    chk(m_total == es + eh + ed, "R8 ce window", m_total, es + eh + ed);
    chk(m_done_ok, "R10 done pulse", int'(m_done_ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hv[3];
    int dv[3];
    int save;
    hv = '{0, 2, 15};
    dv = '{0, 1, 9};
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_adv_n && !bus_oe && !done && req_ready,
        "R10 reset state", {mem_ce_n, mem_we_n, mem_adv_n, bus_oe, done, req_ready}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int fl = 0; fl < 4; fl++)
      for (int em = 0; em < 3; em++)
        for (int as = 0; as < 16; as++)
          for (int hi = 0; hi < 3; hi++)
            for (int di = 0; di < 3; di++)
              run_case(as, hv[hi], dv[di], (em == 1) ? 0 : 3, em != 0,
                       fl[1], fl[0], (as + hi) & 15);

    run_case(2, 3, 255, 0, 1'b0, 1'b0, 1'b0, 0);
    run_case(0, 0, 0, 3, 1'b1, 1'b0, 1'b0, 0);
    run_case(0, 0, 0, 0, 1'b0, 1'b0, 1'b1, 0);

    run_case(5, 4, 6, 3, 1'b1, 1'b0, 1'b0, 0);
    save = m_su * 10000 + m_ho * 100 + m_da;
    run_case(5, 4, 6, 3, 1'b1, 1'b0, 1'b0, 15);
    chk(save == m_su * 10000 + m_ho * 100 + m_da, "R1 turnaround bits ignored",
        m_su * 10000 + m_ho * 100 + m_da, save);
    run_case(5, 4, 6, 2, 1'b1, 1'b0, 1'b0, 0);
    chk(m_ho == 0, "R1 mode field position", m_ho, 0);

    xfer({16'h0000, 8'd4, 4'd0, 4'd3}, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h1357, 1'b1);
    chk(m_total == 7, "R10 busy request ignored length", m_total, 7);
    chk(m_bad_addr == 0 && m_bad_bus == 0, "R10 busy request ignored addr", m_bad_addr + m_bad_bus, 0);
    chk(m_done_ok, "R10 single done after ignored request", int'(m_done_ok), 1);
    chk(mem_ce_n && req_ready, "R10 idle after ignored request", int'(mem_ce_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule